// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs exception entry and exception return for a small 32-bit RISC core. Each cycle it looks at a set of pending exception requests and the program counter of the instruction in flight. When a request is accepted it records the return address, saves and clears the global interrupt enable, and produces a new program counter that points into a table of 32-byte handler slots.

Requests fall into two classes. Normal exceptions are instruction bus error, data bus error, divide by zero, external interrupt and system call. Debug exceptions are breakpoint and watchpoint. Each class has its own return-address register and its own saved-enable bit. Normal exceptions vector through a normal base register unless a remap bit redirects them to the debug base register. Debug exceptions always use the debug base.

Two return strobes restore the program counter and the global enable from the saved state of one class. A register write port lets software set both base registers, the three enable bits and the remap bit. All results are registered and appear one clock after the stimulus.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `pc_out` equals parameter `RESET_BASE` with its low 8 bits forced to zero. `eba` and `deba` hold the same value. `gie`, `eie`, `bie`, `remap`, `pc_load` and `exc_taken` are all 0.
- R2: When a normal exception (codes 2, 4, 5, 6, 7) is accepted, the next cycle shows `ea` equal to the `cur_pc` of the accepting cycle, `eie` equal to the previous `gie`, `gie` at 0, and `pc_load` and `exc_taken` at 1. `ba` and `bie` keep their values.
- R3: When a debug exception (breakpoint code 1, watchpoint code 3) is accepted, the next cycle shows `ba` equal to `cur_pc`, `bie` equal to the previous `gie`, and `gie` at 0. `ea` and `eie` keep their values.
- R4: The new `pc_out` is the selected base plus the exception code times 32. `exc_code` reports that code. The codes are: breakpoint 1, instruction bus error 2, watchpoint 3, data bus error 4, divide by zero 5, interrupt 6, system call 7.
- R5: Normal exceptions vector through `eba` while `remap` is 0, and through `deba` while `remap` is 1.
- R6: Debug exceptions vector through `deba` whatever the value of `remap`.
- R7: When several requests are pending, the winner is chosen in this order, highest first: 1, 2, 4, 3, 5, 7, 6. Input bit `exc_req[k]` requests code k.
- R8: An interrupt request (code 6) is ignored while `gie` is 0. In that case no `pc_load` follows and `ea` is unchanged.
- R9: When `ret_exc` is high and no exception is accepted, `pc_out` takes `ea` and `gie` takes `eie`. When `ret_brk` is high, no exception is accepted and `ret_exc` is low, `pc_out` takes `ba` and `gie` takes `bie`. In both cases `pc_load` is 1 and `exc_taken` is 0 on the next cycle.
- R10: A write with `wr_en` high updates the register chosen by `wr_sel`. The encodings are: 0 for the normal base, 1 for the debug base, 2 for the enable bits (bit 0 `gie`, bit 1 `eie`, bit 2 `bie`), and 3 for the debug-control register (bit 0 `remap`). Bits 7:0 of a base write are ignored and read back as zero.
- R11: An accepted exception or return in the same cycle overrides a write to the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Pending requests, bit k requests code k (bits 7:1) |
| cur_pc | input | 32 | Program counter of the faulting instruction |
| ret_exc | input | 1 | Return from a normal exception |
| ret_brk | input | 1 | Return from a debug exception |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| pc_load | output | 1 | `pc_out` carries a new target this cycle |
| exc_taken | output | 1 | The new target comes from an exception |
| exc_code | output | 3 | Code of the last accepted exception |
| pc_out | output | 32 | Program counter target |
| gie | output | 1 | Global interrupt enable |
| eie | output | 1 | Enable saved on normal exception |
| bie | output | 1 | Enable saved on debug exception |
| remap | output | 1 | Normal exceptions use the debug base |
| ea | output | 32 | Normal-exception return address |
| ba | output | 32 | Debug-exception return address |
| eba | output | 32 | Normal vector base |
| deba | output | 32 | Debug vector base |

## Verification
Every result of this block comes from one register stage. The vector target, the saved address, the enable bits and the two strobes therefore all change at the first rising edge after a request, return or write is presented, and they hold until the next event. The bench drives each stimulus on a falling edge and removes it on the following falling edge, and it reads every output at that second falling edge. It then runs a table of prioritised request patterns and directed cases for same-cycle conflicts. Setup writes have settled by the time the request cycle starts, so each check sees the outcome of exactly one edge.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_BRK   = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIV0  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } exc_code_e;

  typedef enum logic [1:0] {
    SEL_EBA  = 2'd0,
    SEL_DEBA = 2'd1,
    SEL_IE   = 2'd2,
    SEL_DC   = 2'd3
  } reg_sel_e;

  function automatic logic is_debug_code(input logic [2:0] code);
    return (code == EXC_BRK) || (code == EXC_WATCH);
  endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:1] req,
  input  logic       gie,
  output logic       grant_valid,
  output logic [2:0] grant_code
);

  localparam int NRANK = 7;
  // Highest priority first.
  localparam int RANK [NRANK] = '{1, 2, 4, 3, 5, 7, 6};

  logic [7:1] eligible;

  always_comb begin
    eligible = req;
    eligible[EXC_IRQ] = req[EXC_IRQ] & gie;
  end

  always_comb begin
    grant_valid = 1'b0;
    grant_code  = EXC_RESET;
    for (int i = NRANK - 1; i >= 0; i--) begin
      if (eligible[RANK[i]]) begin
        grant_valid = 1'b1;
        grant_code  = 3'(RANK[i]);
      end
    end
  end

  // R7
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_code != EXC_RESET) && req[grant_code]);

  // R7
  brk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[EXC_BRK] |-> grant_valid && grant_code == EXC_BRK);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_code == EXC_IRQ) |-> gie);

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 8,
  parameter int SLOT_SHIFT = 5,
  parameter int CODE_W     = 3
) (
  input  logic [ADDR_W-ALIGN_BITS-1:0] eba_hi,
  input  logic [ADDR_W-ALIGN_BITS-1:0] deba_hi,
  input  logic                         remap,
  input  logic [CODE_W-1:0]            code,
  output logic                         use_debug_base,
  output logic [ADDR_W-1:0]            vec_addr
);

  localparam int LOW_PAD = ALIGN_BITS - CODE_W - SLOT_SHIFT;

  function automatic logic [ADDR_W-1:0] slot_addr(
    input logic [ADDR_W-ALIGN_BITS-1:0] base_hi,
    input logic [CODE_W-1:0]            c
  );
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;
    base = {base_hi, {ALIGN_BITS{1'b0}}};
    offs = ADDR_W'(c) << SLOT_SHIFT;
    return base + offs;
  endfunction

  always_comb begin
    use_debug_base = is_debug_code(code) | remap;
    vec_addr = slot_addr(use_debug_base ? deba_hi : eba_hi, code);
  end

  if (LOW_PAD < 0) begin : g_bad_align
    initial $error("slot table does not fit in the alignment");
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          ALIGN_BITS = 8,
  parameter int          SLOT_SHIFT = 5,
  parameter logic [31:0] RESET_BASE = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:1]        exc_req,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              ret_exc,
  input  logic              ret_brk,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              pc_load,
  output logic              exc_taken,
  output logic [2:0]        exc_code,
  output logic [ADDR_W-1:0] pc_out,
  output logic              gie,
  output logic              eie,
  output logic              bie,
  output logic              remap,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] ba,
  output logic [ADDR_W-1:0] eba,
  output logic [ADDR_W-1:0] deba
);

  localparam int CODE_W = 3;
  localparam int HI_W   = ADDR_W - ALIGN_BITS;
  localparam logic [HI_W-1:0] RST_HI = RESET_BASE[ADDR_W-1:ALIGN_BITS];

  logic [HI_W-1:0]   eba_hi_q, deba_hi_q;
  logic              gie_q, eie_q, bie_q, remap_q;
  logic [ADDR_W-1:0] ea_q, ba_q, pc_q;
  logic              pc_load_q, exc_taken_q;
  logic [2:0]        code_q;

  logic              take;
  logic [2:0]        take_code;
  logic              take_dbg;
  logic              eret_go, bret_go, ie_wr_go;
  logic              dbg_base_used;
  logic [ADDR_W-1:0] vec;

  exc_prio_sel u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (exc_req),
    .gie         (gie_q),
    .grant_valid (take),
    .grant_code  (take_code)
  );

  exc_vec_calc #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .SLOT_SHIFT (SLOT_SHIFT),
    .CODE_W     (CODE_W)
  ) u_vec (
    .eba_hi         (eba_hi_q),
    .deba_hi        (deba_hi_q),
    .remap          (remap_q),
    .code           (take_code),
    .use_debug_base (dbg_base_used),
    .vec_addr       (vec)
  );

  always_comb begin
    take_dbg = take && is_debug_code(take_code);
    eret_go  = ret_exc && !take;
    bret_go  = ret_brk && !take && !ret_exc;
    ie_wr_go = wr_en && (wr_sel == SEL_IE) && !take && !eret_go && !bret_go;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eba_hi_q    <= RST_HI;
      deba_hi_q   <= RST_HI;
      gie_q       <= 1'b0;
      eie_q       <= 1'b0;
      bie_q       <= 1'b0;
      remap_q     <= 1'b0;
      ea_q        <= '0;
      ba_q        <= '0;
      pc_q        <= {RST_HI, {ALIGN_BITS{1'b0}}};
      pc_load_q   <= 1'b0;
      exc_taken_q <= 1'b0;
      code_q      <= EXC_RESET;
    end else begin
      pc_load_q   <= take | eret_go | bret_go;
      exc_taken_q <= take;
      if (take) code_q <= take_code;

      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_EBA:  eba_hi_q  <= wr_data[ADDR_W-1:ALIGN_BITS];
          SEL_DEBA: deba_hi_q <= wr_data[ADDR_W-1:ALIGN_BITS];
          SEL_DC:   remap_q   <= wr_data[0];
          default:  ;
        endcase
      end

      if (take) begin
        pc_q  <= vec;
        gie_q <= 1'b0;
        if (take_dbg) begin
          ba_q  <= cur_pc;
          bie_q <= gie_q;
        end else begin
          ea_q  <= cur_pc;
          eie_q <= gie_q;
        end
      end else if (eret_go) begin
        pc_q  <= ea_q;
        gie_q <= eie_q;
      end else if (bret_go) begin
        pc_q  <= ba_q;
        gie_q <= bie_q;
      end else if (ie_wr_go) begin
        gie_q <= wr_data[0];
        eie_q <= wr_data[1];
        bie_q <= wr_data[2];
      end
    end
  end

  assign pc_load   = pc_load_q;
  assign exc_taken = exc_taken_q;
  assign exc_code  = code_q;
  assign pc_out    = pc_q;
  assign gie       = gie_q;
  assign eie       = eie_q;
  assign bie       = bie_q;
  assign remap     = remap_q;
  assign ea        = ea_q;
  assign ba        = ba_q;
  assign eba       = {eba_hi_q, {ALIGN_BITS{1'b0}}};
  assign deba      = {deba_hi_q, {ALIGN_BITS{1'b0}}};

  // R2
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q && exc_taken_q && pc_load_q);

  // R2
  ea_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_dbg) |=> ea_q == $past(cur_pc) && eie_q == $past(gie_q)
                             && ba_q == $past(ba_q));

  // R3
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> ba_q == $past(cur_pc) && bie_q == $past(gie_q)
                 && ea_q == $past(ea_q));

  // R4
  slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc_q[SLOT_SHIFT-1:0] == '0);

  // R6
  dbg_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |-> dbg_base_used);

  // R9
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eret_go |=> gie_q == $past(eie_q) && pc_q == $past(ea_q) && !exc_taken_q);

  // R9
  bret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bret_go |=> gie_q == $past(bie_q) && pc_q == $past(ba_q));

  // R10
  base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(eba_hi_q) && $stable(deba_hi_q));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

  localparam logic [31:0] RB = 32'h0000_4055;
  localparam logic [31:0] EB = 32'h1000_0000;
  localparam logic [31:0] DB = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  exc_req = '0;
  logic [31:0] cur_pc = '0;
  logic        ret_exc = 1'b0, ret_brk = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        pc_load, exc_taken, gie, eie, bie, remap;
  logic [2:0]  exc_code;
  logic [31:0] pc_out, ea, ba, eba, deba;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_ctrl #(.RESET_BASE(RB)) u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
    .ret_exc(ret_exc), .ret_brk(ret_brk), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pc_load(pc_load), .exc_taken(exc_taken),
    .exc_code(exc_code), .pc_out(pc_out), .gie(gie), .eie(eie), .bie(bie),
    .remap(remap), .ea(ea), .ba(ba), .eba(eba), .deba(deba)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One stimulus cycle: apply at a falling edge, remove and sample at the next.
  task automatic step(input logic [7:0] req, input logic [31:0] pc,
                      input logic re, input logic rb, input logic we,
                      input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    exc_req = req[7:1]; cur_pc = pc; ret_exc = re; ret_brk = rb;
    wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    exc_req = '0; ret_exc = 1'b0; ret_brk = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step(8'h00, 32'h0, 1'b0, 1'b0, 1'b1, sel, d);
  endtask

  function automatic logic [31:0] slot(input logic [31:0] base, input int code);
    return base + 32'(code * 32);
  endfunction

  // {request bits (bit k = code k), gie, remap, expected code, expected pc}
  localparam int NV = 10;
  localparam logic [44:0] VEC [NV] = '{
    {8'b0100_0000, 1'b1, 1'b0, 3'd6, 32'h1000_00C0},
    {8'b1000_0000, 1'b0, 1'b0, 3'd7, 32'h1000_00E0},
    {8'b0100_0010, 1'b1, 1'b0, 3'd1, 32'h2000_0020},
    {8'b0010_1000, 1'b1, 1'b0, 3'd3, 32'h2000_0060},
    {8'b0011_0100, 1'b0, 1'b1, 3'd2, 32'h2000_0040},
    {8'b1001_0000, 1'b1, 1'b0, 3'd4, 32'h1000_0080},
    {8'b1110_0000, 1'b1, 1'b0, 3'd5, 32'h1000_00A0},
    {8'b1100_0000, 1'b1, 1'b0, 3'd7, 32'h1000_00E0},
    {8'b0000_1000, 1'b0, 1'b0, 3'd3, 32'h2000_0060},
    {8'b0000_0010, 1'b1, 1'b1, 3'd1, 32'h2000_0020}
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pc_out", pc_out, 32'h0000_4000);
    check("R1 eba", eba, 32'h0000_4000);
    check("R1 deba", deba, 32'h0000_4000);
    check("R1 flags", {28'b0, gie, eie, bie, remap}, 32'h0);
    check("R1 strobes", {30'b0, pc_load, exc_taken}, 32'h0);

    // R10 base write drops the low byte
    wr(2'd0, 32'h1234_56FF);
    check("R10 eba low bits", eba, 32'h1234_5600);
    wr(2'd1, 32'h2000_00AB);
    check("R10 deba low bits", deba, DB);
    wr(2'd0, EB);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  rq;
      logic        g, rm;
      logic [2:0]  cd;
      logic [31:0] xp, fpc, old_ea, old_ba;
      {rq, g, rm, cd, xp} = VEC[i];
      fpc = 32'h8000_0000 + 32'(i * 4);
      wr(2'd3, {31'b0, rm});
      wr(2'd2, {29'b0, 1'b0, 1'b0, g});
      old_ea = ea; old_ba = ba;
      step(rq, fpc, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
      // R7 priority, R4 vector, R5 base select, R6 debug base
      check($sformatf("R7 code vec%0d", i), {29'b0, exc_code}, {29'b0, cd});
      check($sformatf("R4 R5 R6 pc vec%0d", i), pc_out, xp);
      check($sformatf("R2 strobes vec%0d", i), {29'b0, pc_load, exc_taken, gie}, 32'h6);
      if (cd == 3'd1 || cd == 3'd3) begin
        // R3 debug save
        check($sformatf("R3 ba vec%0d", i), ba, fpc);
        check($sformatf("R3 bie vec%0d", i), {31'b0, bie}, {31'b0, g});
        check($sformatf("R3 ea kept vec%0d", i), ea, old_ea);
      end else begin
        // R2 normal save
        check($sformatf("R2 ea vec%0d", i), ea, fpc);
        check($sformatf("R2 eie vec%0d", i), {31'b0, eie}, {31'b0, g});
        check($sformatf("R2 ba kept vec%0d", i), ba, old_ba);
      end
    end
    wr(2'd3, 32'h0);

    // R8 interrupt masked while gie is 0
    wr(2'd2, 32'h0);
    begin
      logic [31:0] e0;
      e0 = ea;
      step(8'b0100_0000, 32'hDEAD_0000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
      check("R8 no pc_load", {31'b0, pc_load}, 32'h0);
      check("R8 ea unchanged", ea, e0);
    end

    // R9 return from normal exception
    step(8'b1000_0000, 32'h0000_1230, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    wr(2'd2, 32'h2);
    step(8'h00, 32'h0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
    check("R9 eret pc", pc_out, 32'h0000_1230);
    check("R9 eret gie", {29'b0, pc_load, exc_taken, gie}, 32'h5);

    // R9 return from debug exception
    step(8'b0000_0010, 32'h0000_4560, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    wr(2'd2, 32'h4);
    step(8'h00, 32'h0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
    check("R9 bret pc", pc_out, 32'h0000_4560);
    check("R9 bret gie", {31'b0, gie}, 32'h1);

    // R9 ret_exc wins over ret_brk
    wr(2'd2, 32'h4);
    step(8'h00, 32'h0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0);
    check("R9 both returns pc", pc_out, 32'h0000_1230);
    check("R9 both returns gie", {31'b0, gie}, 32'h0);

    // R9 exception wins over a return in the same cycle
    wr(2'd2, 32'h1);
    step(8'b1000_0000, 32'h0000_7770, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
    check("R9 exc over eret pc", pc_out, slot(EB, 7));
    check("R9 exc over eret flags", {30'b0, exc_taken, gie}, 32'h2);

    // R11 exception overrides an enable write in the same cycle
    wr(2'd2, 32'h1);
    step(8'b0010_0000, 32'h0000_8880, 1'b0, 1'b0, 1'b1, 2'd2, 32'h7);
    check("R11 enables", {29'b0, bie, eie, gie}, 32'h2);
    check("R11 pc", pc_out, slot(EB, 5));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule